// File: doc/BRIEF.md
# Floating-Point Divide/Square-Root Structural Hazard Tracker

This block decides, cycle by cycle, whether one floating-point operation may issue. The operation is an add, a multiply, or a divide/square-root in single or double precision. It does not compute any arithmetic. It models only when the shared multiplier, the non-pipelined divider and the single result strobe are free.

An upstream issue stage presents one request per cycle. The block answers with a grant in the same cycle. For every granted operation it later raises a result-ready strobe that carries the operation's tag. It also provides a countdown that tells dependent adds and multiplies when they may consume the newest result.

A divide borrows the multiplier twice: on its first cycle, and again for one rounding cycle near its end. A multiply that falls on either of those cycles is refused. Each resource, and the result strobe, has a shift-register reservation table. On every grant the new operation's occupancy pattern is ORed into these tables.

Top module: `fp_resv_tracker`

## Requirements
- R1: `req_class` encodes 0 = add, 1 = multiply, 2 = divide/square-root and 3 = reserved. `req_double` selects double precision for a divide. A reserved-class request is never granted.
- R2: After a divide is granted in cycle c, `busy` is high in cycles c+1 through c+11 (single) or c+21 (double). A divide request is refused while `busy` is high and is granted from cycle c+12 (single) or c+22 (double).
- R3: During a divide granted in cycle c, a multiply is refused in the rounding cycle c+9 (single) or c+19 (double). It is granted in every other cycle, including a new multiply on each of several consecutive cycles.
- R4: An add is refused only when its result would complete in the same cycle as another granted operation. For a divide granted in cycle c this is the add in cycle c+9 (single) or c+19 (double).
- R5: For each granted operation, `done_valid` is high for exactly one cycle, with `done_tag` equal to the request's tag. For an add or multiply granted in cycle c this is cycle c+4. For a divide it is cycle c+13 (single) or c+23 (double).
- R6: `dep_count` loads 3 after a granted add or multiply, 12 after a granted single divide and 22 after a granted double divide. It then falls by one per cycle until it reaches 0 and holds there. A new grant reloads it.
- R7: After reset, `busy`, `done_valid` and `dep_count` are 0 and no resource is reserved.
- R8: `grant` is valid in the cycle of the request. With `req_valid` low there is no grant and no reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Issue request present this cycle |
| req_class | input | 2 | Operation class (R1 encoding) |
| req_double | input | 1 | Double precision for divide/square-root |
| req_tag | input | TAG_W | Tag returned on completion |
| grant | output | 1 | Request accepted this cycle |
| busy | output | 1 | Divider occupied by an in-flight divide |
| done_valid | output | 1 | An operation completes this cycle |
| done_tag | output | TAG_W | Tag of the completing operation |
| dep_count | output | 5 | Cycles until dependents may use the newest result |

## Verification
`grant` is combinational, so it is checked in the request cycle itself, shortly after the inputs change. `busy`, `dep_count` and `done_valid` come from registers and change one edge after a grant. Each of them is therefore checked after every edge against an index that counts edges since the divide was granted. With that index, the strobe is due at 4, 13 or 23 edges, and the countdown starts one edge after its grant. The sweep places a probe request of every class at every offset within a divide, in both precisions, and derives each expected value from that offset alone.

// File: rtl/fp_resv_tracker.sv
module fp_resv_tracker #(
  parameter int TAG_W     = 4,
  parameter int SGL_MID   = 8,
  parameter int DBL_MID   = 18,
  parameter int ARITH_LAT = 4,
  parameter int ARITH_BYP = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_class,
  input  logic             req_double,
  input  logic [TAG_W-1:0] req_tag,
  output logic             grant,
  output logic             busy,
  output logic             done_valid,
  output logic [TAG_W-1:0] done_tag,
  output logic [$clog2(DBL_MID+7)-1:0] dep_count
);
  localparam int DEPTH = DBL_MID + 6;
  localparam int CW    = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] mul_q, div_q, res_q;
  logic [DEPTH-1:0] mul_pat, div_pat, res_pat;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [CW-1:0]    dep_q;

  logic is_add, is_mul, is_div, known;
  int   mid, lat, byp;

  assign is_add = req_class == 2'd0;
  assign is_mul = req_class == 2'd1;
  assign is_div = req_class == 2'd2;
  assign known  = is_add | is_mul | is_div;

  assign mid = req_double ? DBL_MID : SGL_MID;
  assign lat = is_div ? mid + 5 : ARITH_LAT;
  assign byp = is_div ? mid + 4 : ARITH_BYP;

  always_comb begin
    for (int k = 0; k < DEPTH; k++) begin
      div_pat[k] = is_div && (k <= mid + 3);
      mul_pat[k] = (is_mul && k == 0) || (is_div && (k == 0 || k == mid + 1));
      res_pat[k] = known && (k == lat);
    end
  end

  logic conflict;
  assign conflict = |(mul_q & mul_pat) | |(div_q & div_pat) | |(res_q & res_pat);
  assign grant    = req_valid & known & ~conflict;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mul_q <= '0;
      div_q <= '0;
      res_q <= '0;
      dep_q <= '0;
      for (int k = 0; k < DEPTH; k++) tag_q[k] <= '0;
    end else begin
      mul_q <= (mul_q | (grant ? mul_pat : '0)) >> 1;
      div_q <= (div_q | (grant ? div_pat : '0)) >> 1;
      res_q <= (res_q | (grant ? res_pat : '0)) >> 1;
      for (int k = 0; k < DEPTH - 1; k++)
        tag_q[k] <= (grant && res_pat[k+1]) ? req_tag : tag_q[k+1];
      tag_q[DEPTH-1] <= '0;
      if (grant)           dep_q <= CW'(byp);
      else if (dep_q != 0) dep_q <= dep_q - 1'b1;
    end
  end

  assign busy       = div_q[0];
  assign done_valid = res_q[0];
  assign done_tag   = tag_q[0];
  assign dep_count  = dep_q;
endmodule

// File: rtl/fp_resv_tracker_chk.sv
module fp_resv_tracker_chk #(
  parameter int TAG_W     = 4,
  parameter int SGL_MID   = 8,
  parameter int DBL_MID   = 18,
  parameter int ARITH_BYP = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [1:0]       req_class,
  input logic             req_double,
  input logic             grant,
  input logic             busy,
  input logic             done_valid,
  input logic [$clog2(DBL_MID+7)-1:0] dep_count
);
  localparam int CW = $clog2(DBL_MID + 7);

  logic [CW-1:0] since_div;
  logic [CW-1:0] div_mid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_div <= '0;
      div_mid   <= '0;
    end else if (grant && req_class == 2'd2) begin
      since_div <= CW'(1);
      div_mid   <= CW'(req_double ? DBL_MID : SGL_MID);
    end else if (since_div != 0 && since_div < CW'(DBL_MID + 6)) begin
      since_div <= since_div + 1'b1;
    end
  end

  // R1
  a_r1_reserved_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_class == 2'd3) |-> !grant);

  // R2
  a_r2_div_refused_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_class == 2'd2 && busy) |-> !grant);

  // R2
  a_r2_busy_after_div: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && req_class == 2'd2) |=> busy);

  // R3
  a_r3_round_slot_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_class == 2'd1 && since_div != 0 && since_div == div_mid + 1'b1) |-> !grant);

  // R8
  a_r8_grant_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> req_valid);

  // R6
  a_r6_arith_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && (req_class == 2'd0 || req_class == 2'd1)) |=> dep_count == CW'(ARITH_BYP));

  // R6
  a_r6_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant && dep_count != 0) |=> dep_count == $past(dep_count) - 1'b1);

  // R6
  a_r6_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant && dep_count == 0) |=> dep_count == 0);
endmodule

bind fp_resv_tracker fp_resv_tracker_chk #(
  .TAG_W(TAG_W), .SGL_MID(SGL_MID), .DBL_MID(DBL_MID), .ARITH_BYP(ARITH_BYP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
  .req_double(req_double), .grant(grant), .busy(busy),
  .done_valid(done_valid), .dep_count(dep_count)
);

// File: tb/fp_resv_tracker_bench.sv
`timescale 1ns/1ps
module fp_resv_tracker_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_class = 2'd0;
  logic       req_double = 1'b0;
  logic [3:0] req_tag = 4'd0;
  logic       grant, busy, done_valid;
  logic [3:0] done_tag;
  logic [4:0] dep_count;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #2.5 clk = ~clk;

  fp_resv_tracker u_fp_resv_tracker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
    .req_double(req_double), .req_tag(req_tag), .grant(grant), .busy(busy),
    .done_valid(done_valid), .done_tag(done_tag), .dep_count(dep_count)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(busy == 1'b0, "R7 busy", int'(busy), 0);
    check(done_valid == 1'b0, "R7 done_valid", int'(done_valid), 0);
    check(dep_count == 5'd0, "R7 dep_count", int'(dep_count), 0);
    @(negedge clk);
  endtask

  task automatic run_case(input bit dbl, input logic [1:0] cls, input int k);
    int mid, lat, plat, last, dep_exp;
    bit probe_ok, exp_g, exp_busy, exp_done;
    logic [3:0] exp_tag;
    mid  = dbl ? 18 : 8;
    lat  = mid + 5;
    plat = (cls == 2'd2) ? lat : 4;
    case (cls)
      2'd2:    probe_ok = (k >= mid + 4);
      2'd3:    probe_ok = 1'b0;
      default: probe_ok = (k != mid + 1);
    endcase
    last = k + lat + 3;
    dep_exp = 0;
    do_reset();
    for (int j = 0; j <= last; j++) begin
      if (j == 0) begin
        req_valid = 1'b1; req_class = 2'd2; req_double = dbl; req_tag = 4'hA;
      end else if (j == k) begin
        req_valid = 1'b1; req_class = cls; req_double = dbl; req_tag = 4'h5;
      end else begin
        req_valid = 1'b0;
      end
      #1;
      exp_g = (j == 0) ? 1'b1 : ((j == k) ? probe_ok : 1'b0);
      if (cls == 2'd2)      check(grant == exp_g, "R2 grant", int'(grant), int'(exp_g));
      else if (cls == 2'd1) check(grant == exp_g, "R3 grant", int'(grant), int'(exp_g));
      else if (cls == 2'd0) check(grant == exp_g, "R4 grant", int'(grant), int'(exp_g));
      else                  check(grant == exp_g, "R1 grant", int'(grant), int'(exp_g));
      exp_busy = (j >= 1 && j <= mid + 3) ||
                 (probe_ok && cls == 2'd2 && j >= k + 1 && j <= k + mid + 3);
      check(busy == exp_busy, "R2 busy", int'(busy), int'(exp_busy));
      exp_done = (j == lat) || (probe_ok && j == k + plat);
      check(done_valid == exp_done, "R5 done_valid", int'(done_valid), int'(exp_done));
      if (exp_done) begin
        exp_tag = (j == lat) ? 4'hA : 4'h5;
        check(done_tag == exp_tag, "R5 done_tag", int'(done_tag), int'(exp_tag));
      end
      check(int'(dep_count) == dep_exp, "R6 dep_count", int'(dep_count), dep_exp);
      @(posedge clk);
      if (exp_g) dep_exp = (j == 0 || cls == 2'd2) ? lat - 1 : 3;
      else if (dep_exp > 0) dep_exp = dep_exp - 1;
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  task automatic run_stream();
    int dep_exp;
    bit exp_done;
    dep_exp = 0;
    do_reset();
    for (int j = 0; j < 15; j++) begin
      req_valid = (j < 8); req_class = 2'd1; req_double = 1'b0; req_tag = 4'(j);
      #1;
      check(grant == (j < 8), "R3 back-to-back grant", int'(grant), int'(j < 8));
      exp_done = (j >= 4 && j < 12);
      check(done_valid == exp_done, "R5 stream done_valid", int'(done_valid), int'(exp_done));
      if (exp_done)
        check(done_tag == 4'(j - 4), "R5 stream done_tag", int'(done_tag), j - 4);
      check(int'(dep_count) == dep_exp, "R6 stream dep_count", int'(dep_count), dep_exp);
      @(posedge clk);
      if (j < 8) dep_exp = 3;
      else if (dep_exp > 0) dep_exp = dep_exp - 1;
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  task automatic run_idle();
    do_reset();
    for (int j = 0; j < 6; j++) begin
      req_valid = 1'b0; req_class = 2'd2; req_double = 1'b1;
      #1;
      check(grant == 1'b0, "R8 no grant when idle", int'(grant), 0);
      @(negedge clk);
    end
    req_valid = 1'b1; req_class = 2'd2; req_double = 1'b1; req_tag = 4'h3;
    #1;
    check(grant == 1'b1, "R8 divide after idle granted", int'(grant), 1);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check(busy == 1'b1, "R8 busy after divide", int'(busy), 1);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    run_idle();
    run_stream();
    for (int p = 0; p < 2; p++)
      for (int c = 0; c < 4; c++)
        for (int k = 1; k <= (p != 0 ? 25 : 15); k++)
          run_case(p != 0, 2'(c), k);
    finish_run();
  end

  initial begin
    #(5.0 * 200000);
    if (!ended) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end
endmodule